// File: doc/BRIEF.md
# Fully Associative Translation Cache with Conflict Shutdown

This block caches virtual-to-physical page translations. Every entry stores a virtual page number, a process identifier, a physical page number and a valid flag. A translation may sit in any entry. A lookup presents a virtual page number and the current process identifier. Every entry compares itself against the lookup in parallel, and the single matching entry supplies its physical page number. Software-style writes place an entry at a chosen index.

Two valid entries can hold the same virtual page under the same process identifier. That is an illegal configuration. When a lookup matches more than one entry, the block does not pick a winner. It reports the conflict, sets a sticky shutdown flag and stops translating. From then on every lookup reports a miss until a synchronous reset or an explicit clear. The flag also shows as one bit of a 32-bit status word.

Top module: `assoc_tlb`

## Requirements
- R1: A write with `wr_en` high loads the given virtual page, process identifier, physical page and valid flag into the entry chosen by `wr_idx` (any of the 16 indices). A lookup in the same cycle as the write still sees the old contents. The new contents are visible from the next cycle onward.
- R2: An entry matches only when it is valid and both its virtual page number and its process identifier equal the lookup's values.
- R3: A lookup that matches exactly one entry returns `rsp_valid`=1, `rsp_hit`=1, `rsp_miss`=0, `rsp_multi`=0 and that entry's physical page on `rsp_ppn`, all registered one cycle after `lk_req`.
- R4: A lookup with no matching entry returns `rsp_miss`=1, `rsp_hit`=0 and `rsp_ppn`=0, and it leaves `shutdown` unchanged.
- R5: A lookup that matches two or more entries returns `rsp_multi`=1, `rsp_hit`=0, `rsp_miss`=0 and `rsp_ppn`=0. The physical pages are never combined onto the output. `shutdown` rises in the same cycle as that response.
- R6: While `shutdown` is 1 at the time of a request, the response is `rsp_miss`=1, `rsp_hit`=0, `rsp_multi`=0 and `rsp_ppn`=0, whatever the entries hold.
- R7: `shutdown` is sticky. Only reset or `sd_clear` removes it, one cycle after the clear. A clear leaves the entries intact. A multi-hit in the same cycle as a clear keeps the flag set.
- R8: `status_word` bit 21 equals `shutdown`, and every other bit of `status_word` is 0.
- R9: After a synchronous reset, all entries are invalid, `shutdown` is 0 and all response outputs are 0.
- R10: In the cycle after a cycle with no request, `rsp_valid`, `rsp_hit`, `rsp_miss` and `rsp_multi` are 0 and `rsp_ppn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 20 | Virtual page number to store |
| wr_asid | input | 6 | Process identifier to store |
| wr_ppn | input | 20 | Physical page number to store |
| wr_valid | input | 1 | Valid flag to store |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_asid | input | 6 | Lookup process identifier |
| sd_clear | input | 1 | Clears the shutdown flag |
| rsp_valid | output | 1 | A response is present this cycle |
| rsp_hit | output | 1 | Exactly one entry matched |
| rsp_miss | output | 1 | No entry matched, or translation is disabled |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_ppn | output | 20 | Translated physical page, 0 unless hit |
| shutdown | output | 1 | Sticky conflict flag |
| status_word | output | 32 | Status register, shutdown mirrored at bit 21 |

## Verification
The bench plants a duplicate mapping and checks that the result is a conflict report with a zero page. A design that OR-combined the matches would return a mixed page number and claim a hit. A design that resolved the conflict by priority would return one of the two pages. The bench then checks that translation stays disabled across idle cycles and after valid single-match lookups. A design that forgot the flag would resume hitting. The bench also checks that a clear keeps the entries, and that a conflict coinciding with a clear wins. It covers mismatches that differ only in process identifier or only in the valid flag, which a sloppy compare would accept. A lookup in the same cycle as a write must not see the new entry, so a design with write bypass would show an early hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Outcome of one lookup before it is registered
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_HIT   = 2'd1,
    RSP_MISS  = 2'd2,
    RSP_MULTI = 2'd3
  } rsp_kind_t;

  // True when more than one bit of a match vector is set
  function automatic logic more_than_one(input logic [63:0] v);
    return |(v & (v - 64'd1));
  endfunction

endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
  parameter int VPN_W  = 20,
  parameter int ASID_W = 6,
  parameter int PPN_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [VPN_W-1:0]  w_vpn,
  input  logic [ASID_W-1:0] w_asid,
  input  logic [PPN_W-1:0]  w_ppn,
  input  logic              w_valid,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  output logic              match,
  output logic [PPN_W-1:0]  ppn
);

  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic [PPN_W-1:0]  ppn_q;
  logic              valid_q;

  // Only the valid flag needs reset; the payload is don't-care while invalid
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (we) begin
      valid_q <= w_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      vpn_q  <= w_vpn;
      asid_q <= w_asid;
      ppn_q  <= w_ppn;
    end
  end

  assign match = valid_q && (vpn_q == q_vpn) && (asid_q == q_asid);
  assign ppn   = ppn_q;

endmodule

// File: rtl/tlb_select.sv
module tlb_select #(
  parameter int N     = 16,
  parameter int PPN_W = 20
) (
  input  logic [N-1:0]       match_vec,
  input  logic [N*PPN_W-1:0] ppn_flat,
  output logic               single,
  output logic               multi,
  output logic [PPN_W-1:0]   sel_ppn
);
  import tlb_pkg::*;

  logic [63:0]      wide;
  logic [PPN_W-1:0] and_or;

  always_comb begin
    wide = '0;
    wide[N-1:0] = match_vec;
  end

  assign multi  = more_than_one(wide);
  assign single = (|match_vec) && !multi;

  // One-hot AND-OR; its result is used only when exactly one bit is set
  always_comb begin
    and_or = '0;
    for (int i = 0; i < N; i++) begin
      and_or = and_or | ({PPN_W{match_vec[i]}} & ppn_flat[i*PPN_W +: PPN_W]);
    end
  end

  assign sel_ppn = single ? and_or : '0;

endmodule

// File: rtl/tlb_resp_ctl.sv
module tlb_resp_ctl #(
  parameter int PPN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_req,
  input  logic             single,
  input  logic             multi,
  input  logic [PPN_W-1:0] sel_ppn,
  input  logic             sd_clear,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_multi,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             shutdown
);
  import tlb_pkg::*;

  rsp_kind_t kind;

  always_comb begin
    if (!lk_req)       kind = RSP_NONE;
    else if (shutdown) kind = RSP_MISS;
    else if (multi)    kind = RSP_MULTI;
    else if (single)   kind = RSP_HIT;
    else               kind = RSP_MISS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_ppn   <= '0;
      shutdown  <= 1'b0;
    end else begin
      rsp_valid <= (kind != RSP_NONE);
      rsp_hit   <= (kind == RSP_HIT);
      rsp_miss  <= (kind == RSP_MISS);
      rsp_multi <= (kind == RSP_MULTI);
      rsp_ppn   <= (kind == RSP_HIT) ? sel_ppn : '0;
      if (kind == RSP_MULTI)  shutdown <= 1'b1;
      else if (sd_clear)      shutdown <= 1'b0;
    end
  end

endmodule

// File: rtl/assoc_tlb.sv
module assoc_tlb #(
  parameter int N        = 16,
  parameter int VPN_W    = 20,
  parameter int ASID_W   = 6,
  parameter int PPN_W    = 20,
  parameter int STATUS_W = 32,
  parameter int SD_BIT   = 21,
  localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic                wr_valid,
  input  logic                lk_req,
  input  logic [VPN_W-1:0]    lk_vpn,
  input  logic [ASID_W-1:0]   lk_asid,
  input  logic                sd_clear,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic                rsp_multi,
  output logic [PPN_W-1:0]    rsp_ppn,
  output logic                shutdown,
  output logic [STATUS_W-1:0] status_word
);

  logic [N-1:0]       match_vec;
  logic [N*PPN_W-1:0] ppn_flat;
  logic               single;
  logic               multi;
  logic [PPN_W-1:0]   sel_ppn;

  for (genvar g = 0; g < N; g++) begin : g_entry
    logic we_g;
    assign we_g = wr_en && (wr_idx == IDX_W'(g));
    tlb_entry #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) u_entry (
      .clk     (clk),
      .rst     (rst),
      .we      (we_g),
      .w_vpn   (wr_vpn),
      .w_asid  (wr_asid),
      .w_ppn   (wr_ppn),
      .w_valid (wr_valid),
      .q_vpn   (lk_vpn),
      .q_asid  (lk_asid),
      .match   (match_vec[g]),
      .ppn     (ppn_flat[g*PPN_W +: PPN_W])
    );
  end

  tlb_select #(.N(N), .PPN_W(PPN_W)) u_sel (
    .match_vec (match_vec),
    .ppn_flat  (ppn_flat),
    .single    (single),
    .multi     (multi),
    .sel_ppn   (sel_ppn)
  );

  tlb_resp_ctl #(.PPN_W(PPN_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .lk_req    (lk_req),
    .single    (single),
    .multi     (multi),
    .sel_ppn   (sel_ppn),
    .sd_clear  (sd_clear),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_multi (rsp_multi),
    .rsp_ppn   (rsp_ppn),
    .shutdown  (shutdown)
  );

  for (genvar b = 0; b < STATUS_W; b++) begin : g_status
    if (b == SD_BIT) begin : g_sd
      assign status_word[b] = shutdown;
    end else begin : g_zero
      assign status_word[b] = 1'b0;
    end
  end

endmodule

// File: rtl/assoc_tlb_chk.sv
module assoc_tlb_chk #(
  parameter int PPN_W    = 20,
  parameter int STATUS_W = 32,
  parameter int SD_BIT   = 21
) (
  input logic                clk,
  input logic                rst,
  input logic                lk_req,
  input logic                sd_clear,
  input logic                rsp_valid,
  input logic                rsp_hit,
  input logic                rsp_miss,
  input logic                rsp_multi,
  input logic [PPN_W-1:0]    rsp_ppn,
  input logic                shutdown,
  input logic [STATUS_W-1:0] status_word
);

  // R3
  resp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_multi && rsp_ppn == '0);

  // R4
  miss_zero_ppn_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> rsp_ppn == '0);

  // R5
  outcome_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_multi}) == 1);

  // R5
  multi_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> shutdown);

  // R6
  disabled_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $past(shutdown) && rsp_valid |-> rsp_miss && !rsp_hit && !rsp_multi);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown && !sd_clear |=> shutdown);

  // R4
  miss_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_miss && !$past(sd_clear) |-> shutdown == $past(shutdown));

  // R8
  status_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    status_word == (STATUS_W'(shutdown) << SD_BIT));

endmodule

bind assoc_tlb assoc_tlb_chk #(.PPN_W(PPN_W), .STATUS_W(STATUS_W), .SD_BIT(SD_BIT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lk_req      (lk_req),
  .sd_clear    (sd_clear),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_miss    (rsp_miss),
  .rsp_multi   (rsp_multi),
  .rsp_ppn     (rsp_ppn),
  .shutdown    (shutdown),
  .status_word (status_word)
);

// File: tb/assoc_tlb_test.sv
module assoc_tlb_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, wr_valid, lk_req, sd_clear;
  logic [3:0]  wr_idx;
  logic [19:0] wr_vpn, wr_ppn, lk_vpn;
  logic [5:0]  wr_asid, lk_asid;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_multi, shutdown;
  logic [19:0] rsp_ppn;
  logic [31:0] status_word;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc_tlb uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
    .wr_asid(wr_asid), .wr_ppn(wr_ppn), .wr_valid(wr_valid), .lk_req(lk_req),
    .lk_vpn(lk_vpn), .lk_asid(lk_asid), .sd_clear(sd_clear),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_multi(rsp_multi), .rsp_ppn(rsp_ppn), .shutdown(shutdown),
    .status_word(status_word)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp=completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // Expected full response vector {valid,hit,miss,multi,ppn}
  task automatic check_rsp(input string req, input bit v, input bit h, input bit m,
                           input bit mu, input logic [19:0] p);
    logic [23:0] act, exp;
    act = {rsp_valid, rsp_hit, rsp_miss, rsp_multi, rsp_ppn};
    exp = {v, h, m, mu, p};
    check(act == exp, req, {8'h0, act}, {8'h0, exp});
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_idx = 0; wr_vpn = 0; wr_asid = 0; wr_ppn = 0; wr_valid = 0;
    lk_req = 0; lk_vpn = 0; lk_asid = 0; sd_clear = 0;
  endtask

  task automatic do_write(input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                          input logic [19:0] ppn, input bit vld);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_vpn = vpn; wr_asid = asid; wr_ppn = ppn; wr_valid = vld;
    @(negedge clk);
    wr_en = 0;
  endtask

  // Issues a lookup; on return the registered response is on the outputs
  task automatic do_lookup(input logic [19:0] vpn, input logic [5:0] asid);
    @(negedge clk);
    lk_req = 1; lk_vpn = vpn; lk_asid = asid;
    @(negedge clk);
    lk_req = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check_rsp("R9 reset outputs", 0, 0, 0, 0, 20'h0);
    check(shutdown == 0, "R9 reset shutdown", 32'(shutdown), 0);
    check(status_word == 0, "R8 status after reset", status_word, 0);
    do_lookup(20'h0, 6'h0);
    check_rsp("R9 empty table misses", 1, 0, 1, 0, 20'h0);
  endtask

  task automatic t_basic_hits();
    do_write(0, 20'h12345, 6'h01, 20'hABCDE, 1);
    do_write(1, 20'h00010, 6'h01, 20'h00777, 1);
    do_write(15, 20'hFFFFF, 6'h3F, 20'h5A5A5, 1);
    do_lookup(20'h12345, 6'h01);
    check_rsp("R3 hit entry 0", 1, 1, 0, 0, 20'hABCDE);
    do_lookup(20'h00010, 6'h01);
    check_rsp("R3 hit entry 1", 1, 1, 0, 0, 20'h00777);
    do_lookup(20'hFFFFF, 6'h3F);
    check_rsp("R1 hit top index 15", 1, 1, 0, 0, 20'h5A5A5);
    @(negedge clk);
    check_rsp("R10 no request quiet", 0, 0, 0, 0, 20'h0);
  endtask

  task automatic t_mismatch();
    do_lookup(20'h12345, 6'h02);
    check_rsp("R2 asid mismatch misses", 1, 0, 1, 0, 20'h0);
    do_write(2, 20'h22222, 6'h01, 20'h33333, 0);
    do_lookup(20'h22222, 6'h01);
    check_rsp("R2 invalid entry misses", 1, 0, 1, 0, 20'h0);
    check(shutdown == 0, "R4 miss keeps shutdown low", 32'(shutdown), 0);
  endtask

  task automatic t_write_lookup_same_cycle();
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd3; wr_vpn = 20'h44444; wr_asid = 6'h05; wr_ppn = 20'h66666; wr_valid = 1;
    lk_req = 1; lk_vpn = 20'h44444; lk_asid = 6'h05;
    @(negedge clk);
    wr_en = 0; lk_req = 0;
    check_rsp("R1 same-cycle write not seen", 1, 0, 1, 0, 20'h0);
    do_lookup(20'h44444, 6'h05);
    check_rsp("R1 write visible next cycle", 1, 1, 0, 0, 20'h66666);
  endtask

  task automatic t_multi_hit();
    do_write(5, 20'h12345, 6'h01, 20'h11111, 1);
    do_lookup(20'h12345, 6'h01);
    check_rsp("R5 multi-hit response", 1, 0, 0, 1, 20'h0);
    check(shutdown == 1, "R5 shutdown set with response", 32'(shutdown), 1);
    check(status_word == 32'h0020_0000, "R8 status bit 21", status_word, 32'h0020_0000);
    do_lookup(20'h00010, 6'h01);
    check_rsp("R6 disabled single match", 1, 0, 1, 0, 20'h0);
    repeat (3) @(negedge clk);
    check(shutdown == 1, "R7 flag sticky while idle", 32'(shutdown), 1);
  endtask

  task automatic t_clear();
    @(negedge clk); sd_clear = 1;
    @(negedge clk); sd_clear = 0;
    check(shutdown == 0, "R7 clear drops flag", 32'(shutdown), 0);
    check(status_word == 0, "R8 status after clear", status_word, 0);
    do_lookup(20'h00010, 6'h01);
    check_rsp("R7 entries kept after clear", 1, 1, 0, 0, 20'h00777);
    // conflict together with clear: set wins
    @(negedge clk);
    sd_clear = 1; lk_req = 1; lk_vpn = 20'h12345; lk_asid = 6'h01;
    @(negedge clk);
    sd_clear = 0; lk_req = 0;
    check_rsp("R5 conflict again", 1, 0, 0, 1, 20'h0);
    check(shutdown == 1, "R7 set wins over clear", 32'(shutdown), 1);
    do_write(5, 20'h12345, 6'h01, 20'h11111, 0);
    @(negedge clk); sd_clear = 1;
    @(negedge clk); sd_clear = 0;
    do_lookup(20'h12345, 6'h01);
    check_rsp("R3 hit after conflict removed", 1, 1, 0, 0, 20'hABCDE);
  endtask

  task automatic t_reset_midrun();
    do_write(6, 20'h44444, 6'h05, 20'h99999, 1);
    do_lookup(20'h44444, 6'h05);
    check(shutdown == 1, "R5 second conflict", 32'(shutdown), 1);
    do_reset();
    check(shutdown == 0, "R9 reset clears flag", 32'(shutdown), 0);
    do_lookup(20'h12345, 6'h01);
    check_rsp("R9 reset invalidates entries", 1, 0, 1, 0, 20'h0);
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    t_reset();
    t_basic_hits();
    t_mismatch();
    t_write_lookup_same_cycle();
    t_multi_hit();
    t_clear();
    t_reset_midrun();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule